// File: doc/BRIEF.md
# Disjoint planar switch box

This block is the programmable junction that sits at the crossing of a horizontal and a vertical routing channel in a fabric whose wires are unsegmented. Every wire segment covers a single tile and ends in a box like this one. Longer routes are made by closing switches inside successive boxes. Each of the four sides (north, east, south, west) carries the same number of tracks, `W`. A bidirectional pass switch cannot be synthesized, so each track end is modelled as a separate input and a separate output.

The switch pattern keeps track numbers apart. Track `k` on a side can only be joined to track `k` on the other three sides. This gives every wire end three possible partners (flexibility 3). Each track index has six switches, one for each unordered pair of sides, so the box holds `6*W` configuration bits. Those bits are loaded serially into a shadow chain. A small loader state machine copies the chain into the live switch settings once shifting stops, so the routing never sees a half-loaded image.

Loader states: `CFG_IDLE` (nothing pending), `CFG_SHIFT` (bits are entering the chain), `CFG_APPLY` (the chain is copied into the live settings on the next edge). Transitions:
- *start_load*: `CFG_IDLE` to `CFG_SHIFT` when `cfg_shift` is high.
- *keep_shifting*: `CFG_SHIFT` to `CFG_SHIFT` while it stays high.
- *end_load*: `CFG_SHIFT` to `CFG_APPLY` when it is low.
- *commit_idle*: `CFG_APPLY` to `CFG_IDLE` when it is low.
- *commit_resume*: `CFG_APPLY` to `CFG_SHIFT` when it is high.
- *hold*: `CFG_IDLE` to `CFG_IDLE` when it is low.

Top module: `disjoint_switch_box`

## Requirements
- R1: Output track `k` on any side depends only on the track-`k` inputs of the other sides. If all four track-`k` inputs are 0, all four track-`k` outputs are 0.
- R2: Live bit `6k+p` controls the switch of track `k` for side pair `p`, where p=0 is north-east, 1 is north-south, 2 is north-west, 3 is east-south, 4 is east-west and 5 is south-west.
- R3: A side's track-`k` output is the OR of the track-`k` inputs of every side joined to it by an enabled switch. It is 0 when no switch of that side and track is enabled.
- R4: A side's output never includes that side's own input, so no signal leaves through the side it entered.
- R5: One switch bit joins its pair in both directions. Enabling north-east routes `n_in[k]` to `e_out[k]` and `e_in[k]` to `n_out[k]`.
- R6: On each rising edge with `cfg_shift` high, `cfg_din` enters chain bit `6W-1` and every other chain bit moves one place down. After `6W` shifts, the first bit shifted in sits at bit 0.
- R7: The live settings change only on the rising edge that follows an edge where `cfg_shift` was low and the edge before that was a shifting one. Outputs stay stable while shifting continues.
- R8: An active-low asynchronous reset turns every switch off, clears the chain and returns the loader to `CFG_IDLE`. All outputs then read 0 whatever the inputs.
- R9: If `cfg_shift` rises again in `CFG_APPLY`, the commit and a new shift take place on the same edge. The committed image is the chain as it was before that shift.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Configuration clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| cfg_shift | input | 1 | Shift enable for the configuration chain |
| cfg_din | input | 1 | Serial configuration bit |
| n_in | input | W | Track ends arriving from the north segment |
| e_in | input | W | Track ends arriving from the east segment |
| s_in | input | W | Track ends arriving from the south segment |
| w_in | input | W | Track ends arriving from the west segment |
| n_out | output | W | Track ends driven into the north segment |
| e_out | output | W | Track ends driven into the east segment |
| s_out | output | W | Track ends driven into the south segment |
| w_out | output | W | Track ends driven into the west segment |

## Verification
The overlap of interest is the commit of a new switch image with a fresh shift in the same edge, while track values keep flowing through the old image. The bench provokes this by pausing a load for exactly one cycle and then raising `cfg_shift` again while the loader is in `CFG_APPLY`. Random track values change on every cycle throughout. A behavioural model holds its own shift history and switch image. On every cycle it predicts all four outputs from the track inputs, and the design must match it in the cycle before, in the cycle of, and in the cycle after the commit.

// File: rtl/sb_pkg.sv
package sb_pkg;

    // Loader state encoding
    typedef enum logic [1:0] {
        CFG_IDLE  = 2'd0,
        CFG_SHIFT = 2'd1,
        CFG_APPLY = 2'd2
    } cfg_state_t;

    // Number of side pairs per track index
    localparam int SB_PAIRS = 6;

    // Side-pair positions inside one track's six configuration bits
    localparam int PAIR_NE = 0;
    localparam int PAIR_NS = 1;
    localparam int PAIR_NW = 2;
    localparam int PAIR_ES = 3;
    localparam int PAIR_EW = 4;
    localparam int PAIR_SW = 5;

endpackage

// File: rtl/sb_cfg_loader.sv
module sb_cfg_loader
    import sb_pkg::*;
#(
    parameter int NBITS = 24
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             cfg_shift,
    input  logic             cfg_din,
    output logic [NBITS-1:0] shadow_q,
    output logic [NBITS-1:0] active_q,
    output cfg_state_t       state_q
);

    cfg_state_t state_d;
    logic       do_shift;
    logic       do_commit;

    // State register
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            state_q <= CFG_IDLE;
        end else begin
            state_q <= state_d;
        end
    end

    // Next state and control outputs
    always_comb begin
        state_d   = state_q;
        do_shift  = 1'b0;
        do_commit = 1'b0;
        unique case (state_q)
            CFG_IDLE: begin
                if (cfg_shift) begin
                    do_shift = 1'b1;
                    state_d  = CFG_SHIFT;      // start_load
                end
            end
            CFG_SHIFT: begin
                if (cfg_shift) begin
                    do_shift = 1'b1;           // keep_shifting
                end else begin
                    state_d  = CFG_APPLY;      // end_load
                end
            end
            CFG_APPLY: begin
                do_commit = 1'b1;
                if (cfg_shift) begin
                    do_shift = 1'b1;
                    state_d  = CFG_SHIFT;      // commit_resume
                end else begin
                    state_d  = CFG_IDLE;       // commit_idle
                end
            end
            default: begin
                state_d = CFG_IDLE;
            end
        endcase
    end

    // Serial chain: new bit enters at the top
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            shadow_q <= '0;
        end else if (do_shift) begin
            shadow_q <= {cfg_din, shadow_q[NBITS-1:1]};
        end
    end

    // Live switch settings: the copy takes the pre-shift chain
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            active_q <= '0;
        end else if (do_commit) begin
            active_q <= shadow_q;
        end
    end

endmodule

// File: rtl/sb_track_slice.sv
module sb_track_slice
    import sb_pkg::*;
(
    input  logic [SB_PAIRS-1:0] sw,
    input  logic                n_i,
    input  logic                e_i,
    input  logic                s_i,
    input  logic                w_i,
    output logic                n_o,
    output logic                e_o,
    output logic                s_o,
    output logic                w_o
);

    // Each output gathers only the other three sides
    always_comb begin
        n_o = (sw[PAIR_NE] & e_i) | (sw[PAIR_NS] & s_i) | (sw[PAIR_NW] & w_i);
        e_o = (sw[PAIR_NE] & n_i) | (sw[PAIR_ES] & s_i) | (sw[PAIR_EW] & w_i);
        s_o = (sw[PAIR_NS] & n_i) | (sw[PAIR_ES] & e_i) | (sw[PAIR_SW] & w_i);
        w_o = (sw[PAIR_NW] & n_i) | (sw[PAIR_EW] & e_i) | (sw[PAIR_SW] & s_i);
    end

endmodule

// File: rtl/disjoint_switch_box.sv
module disjoint_switch_box
    import sb_pkg::*;
#(
    parameter int W = 4
) (
    input  logic         clk,
    input  logic         rst_n,
    input  logic         cfg_shift,
    input  logic         cfg_din,
    input  logic [W-1:0] n_in,
    input  logic [W-1:0] e_in,
    input  logic [W-1:0] s_in,
    input  logic [W-1:0] w_in,
    output logic [W-1:0] n_out,
    output logic [W-1:0] e_out,
    output logic [W-1:0] s_out,
    output logic [W-1:0] w_out
);

    localparam int CFG_BITS = SB_PAIRS * W;

    logic [CFG_BITS-1:0] shadow_cfg;
    logic [CFG_BITS-1:0] active_cfg;
    cfg_state_t          cfg_state;

    sb_cfg_loader #(
        .NBITS(CFG_BITS)
    ) u_loader (
        .clk      (clk),
        .rst_n    (rst_n),
        .cfg_shift(cfg_shift),
        .cfg_din  (cfg_din),
        .shadow_q (shadow_cfg),
        .active_q (active_cfg),
        .state_q  (cfg_state)
    );

    for (genvar k = 0; k < W; k++) begin : g_track
        sb_track_slice u_slice (
            .sw (active_cfg[SB_PAIRS*k +: SB_PAIRS]),
            .n_i(n_in[k]),
            .e_i(e_in[k]),
            .s_i(s_in[k]),
            .w_i(w_in[k]),
            .n_o(n_out[k]),
            .e_o(e_out[k]),
            .s_o(s_out[k]),
            .w_o(w_out[k])
        );
    end

endmodule

// File: rtl/sb_checker.sv
module sb_checker
    import sb_pkg::*;
#(
    parameter int W = 4
) (
    input logic         clk,
    input logic         rst_n,
    input logic         cfg_shift,
    input logic [W-1:0] n_in,
    input logic [W-1:0] e_in,
    input logic [W-1:0] s_in,
    input logic [W-1:0] w_in,
    input logic [W-1:0] n_out,
    input logic [W-1:0] e_out,
    input logic [W-1:0] s_out,
    input logic [W-1:0] w_out,
    input cfg_state_t   cfg_state
);

    for (genvar k = 0; k < W; k++) begin : g_chk
        // R1: a quiet track index stays quiet on every side
        assert_track_confined_R1: assert property (@(posedge clk) disable iff (!rst_n)
            ({n_in[k], e_in[k], s_in[k], w_in[k]} == 4'b0000)
            |-> ({n_out[k], e_out[k], s_out[k], w_out[k]} == 4'b0000));

        // R4: a lone north driver never returns north
        assert_no_echo_north_R4: assert property (@(posedge clk) disable iff (!rst_n)
            (n_in[k] && !e_in[k] && !s_in[k] && !w_in[k]) |-> !n_out[k]);

        // R4: a lone south driver never returns south
        assert_no_echo_south_R4: assert property (@(posedge clk) disable iff (!rst_n)
            (s_in[k] && !n_in[k] && !e_in[k] && !w_in[k]) |-> !s_out[k]);
    end

    // R7: no commit can land while shifting continues
    assert_stable_while_shifting_R7: assert property (@(posedge clk) disable iff (!rst_n)
        ($past(cfg_shift, 2) && $stable(n_in) && $stable(e_in) && $stable(s_in) && $stable(w_in))
        |-> ($stable(n_out) && $stable(e_out) && $stable(s_out) && $stable(w_out)));

    // R7: the apply state is entered only from shifting
    assert_apply_after_shift_R7: assert property (@(posedge clk) disable iff (!rst_n)
        (cfg_state == CFG_APPLY) |-> ($past(cfg_state) == CFG_SHIFT));

    // R9: apply never lasts more than one cycle
    assert_apply_single_R9: assert property (@(posedge clk) disable iff (!rst_n)
        (cfg_state == CFG_APPLY) |=> (cfg_state != CFG_APPLY));

endmodule

bind disjoint_switch_box sb_checker #(.W(W)) u_chk (
    .clk      (clk),
    .rst_n    (rst_n),
    .cfg_shift(cfg_shift),
    .n_in     (n_in),
    .e_in     (e_in),
    .s_in     (s_in),
    .w_in     (w_in),
    .n_out    (n_out),
    .e_out    (e_out),
    .s_out    (s_out),
    .w_out    (w_out),
    .cfg_state(cfg_state)
);

// File: tb/disjoint_switch_box_tb.sv
module disjoint_switch_box_tb;

    localparam int W  = 4;
    localparam int NB = 6 * W;
    localparam int WATCHDOG_CYCLES = 200000;

    logic         clk = 1'b0;
    logic         rst_n = 1'b0;
    logic         cfg_shift = 1'b0;
    logic         cfg_din = 1'b0;
    logic [W-1:0] n_in = '0, e_in = '0, s_in = '0, w_in = '0;
    logic [W-1:0] n_out, e_out, s_out, w_out;

    int vectors = 0;
    int errors  = 0;

    // Behavioural reference state
    logic [NB-1:0] m_chain  = '0;
    logic [NB-1:0] m_active = '0;
    logic          hist1 = 1'b0;   // shift enable one edge ago
    logic          hist2 = 1'b0;   // shift enable two edges ago

    always #4 clk = ~clk;          // 125 MHz

    disjoint_switch_box #(.W(W)) u_dut (
        .clk(clk), .rst_n(rst_n), .cfg_shift(cfg_shift), .cfg_din(cfg_din),
        .n_in(n_in), .e_in(e_in), .s_in(s_in), .w_in(w_in),
        .n_out(n_out), .e_out(e_out), .s_out(s_out), .w_out(w_out)
    );

    // Side numbering: 0 north, 1 east, 2 south, 3 west.
    // Pair order (R2): NE, NS, NW, ES, EW, SW.
    function automatic int pair_a(int p);
        case (p)
            0, 1, 2: return 0;
            3, 4:    return 1;
            default: return 2;
        endcase
    endfunction

    function automatic int pair_b(int p);
        case (p)
            0:       return 1;
            1, 3:    return 2;
            default: return 3;
        endcase
    endfunction

    function automatic logic [W-1:0] side_in(int sd);
        case (sd)
            0:       return n_in;
            1:       return e_in;
            2:       return s_in;
            default: return w_in;
        endcase
    endfunction

    function automatic logic [W-1:0] expect_out(int sd);
        logic [W-1:0] r = '0;
        for (int k = 0; k < W; k++) begin
            for (int p = 0; p < 6; p++) begin
                if (m_active[6*k+p]) begin
                    logic [W-1:0] src;
                    if (pair_a(p) == sd) begin
                        src = side_in(pair_b(p));
                        r[k] = r[k] | src[k];
                    end else if (pair_b(p) == sd) begin
                        src = side_in(pair_a(p));
                        r[k] = r[k] | src[k];
                    end
                end
            end
        end
        return r;
    endfunction

    function automatic logic [W-1:0] rnd_bus();
        logic [W-1:0] v;
        for (int i = 0; i < W; i++) v[i] = 1'($urandom % 2);
        return v;
    endfunction

    task automatic compare(input string tag);
        logic [4*W-1:0] got, exp;
        got = {n_out, e_out, s_out, w_out};
        exp = {expect_out(0), expect_out(1), expect_out(2), expect_out(3)};
        vectors++;
        if (got !== exp) begin
            errors++;
            $display("FAIL %s t=%0t actual=%h expected=%h", tag, $time, got, exp);
        end
    endtask

    // One cycle, driven at the falling edge
    task automatic tick(input logic sh, input logic d, input logic [4*W-1:0] tracks,
                        input string tag);
        cfg_shift = sh;
        cfg_din   = d;
        {n_in, e_in, s_in, w_in} = tracks;
        #1;
        compare(tag);
        @(posedge clk);
        if (hist2 && !hist1) m_active = m_chain;
        if (sh) m_chain = {d, m_chain[NB-1:1]};
        hist2 = hist1;
        hist1 = sh;
        @(negedge clk);
    endtask

    function automatic logic [4*W-1:0] rnd_tracks();
        return {rnd_bus(), rnd_bus(), rnd_bus(), rnd_bus()};
    endfunction

    task automatic do_reset(input string tag);
        rst_n = 1'b0;
        cfg_shift = 1'b0;
        {n_in, e_in, s_in, w_in} = '1;
        m_chain = '0; m_active = '0; hist1 = 1'b0; hist2 = 1'b0;
        #1;
        compare(tag);
        @(posedge clk);
        @(negedge clk);
        #1;
        compare(tag);
        rst_n = 1'b1;
        @(negedge clk);
    endtask

    // Bit 0 is shifted first so it lands at index 0 (R6)
    task automatic load(input logic [NB-1:0] img, input string tag);
        for (int i = 0; i < NB; i++) tick(1'b1, img[i], rnd_tracks(), tag);
        tick(1'b0, 1'b0, rnd_tracks(), tag);
        tick(1'b0, 1'b0, rnd_tracks(), tag);
    endtask

    task automatic sweep(int n, input string tag);
        for (int i = 0; i < n; i++) tick(1'b0, 1'b0, rnd_tracks(), tag);
    endtask

    task automatic finish_run();
        $display("== %0d vectors applied, %0d miscompares ==", vectors, errors);
        $finish;
    endtask

    initial begin
        repeat (WATCHDOG_CYCLES) @(posedge clk);
        errors++;
        $display("FAIL watchdog actual=running expected=done");
        finish_run();
    end

    initial begin
        logic [NB-1:0] img;
        @(negedge clk);
        // R8: reset state with every input high
        do_reset("R8 reset");
        sweep(4, "R8 idle after reset");

        // R2 R5: a single north-east switch on track 0
        img = '0; img[0] = 1'b1;
        load(img, "R2 R5 north-east track0");
        tick(1'b0, 1'b0, {W'(1), {W{1'b0}}, {W{1'b0}}, {W{1'b0}}}, "R5 north to east");
        tick(1'b0, 1'b0, {{W{1'b0}}, W'(1), {W{1'b0}}, {W{1'b0}}}, "R5 east to north");
        sweep(10, "R2 R5 random");

        // R2: each pair alone on the top track
        for (int p = 0; p < 6; p++) begin
            img = '0; img[6*(W-1)+p] = 1'b1;
            load(img, "R2 single pair");
            sweep(6, "R2 single pair random");
        end

        // R3 R4: every switch on, OR of three sides, no echo
        load('1, "R3 all on");
        tick(1'b0, 1'b0, {W'(1), {W{1'b0}}, {W{1'b0}}, {W{1'b0}}}, "R4 lone north");
        tick(1'b0, 1'b0, {{W{1'b1}}, {W{1'b1}}, {W{1'b1}}, {W{1'b1}}}, "R3 all high");
        sweep(20, "R3 R4 all on random");

        // R1: tracks disjoint, random images
        for (int j = 0; j < 30; j++) begin
            for (int i = 0; i < NB; i++) img[i] = 1'($urandom % 2);
            load(img, "R1 R6 random image");
            sweep(8, "R1 R3 random traffic");
        end

        // R7: long shift keeps outputs on old image
        for (int i = 0; i < 3 * NB; i++) tick(1'b1, 1'($urandom % 2), rnd_tracks(), "R7 shifting");
        sweep(3, "R7 commit");

        // R9: pause one cycle then resume during apply
        for (int j = 0; j < 20; j++) begin
            for (int i = 0; i < 5; i++) tick(1'b1, 1'($urandom % 2), rnd_tracks(), "R9 shift");
            tick(1'b0, 1'b0, rnd_tracks(), "R9 pause");
            for (int i = 0; i < 4; i++) tick(1'b1, 1'($urandom % 2), rnd_tracks(), "R9 resume");
            sweep(3, "R9 settle");
        end

        // R8: reset in the middle of a load
        for (int i = 0; i < 7; i++) tick(1'b1, 1'b1, rnd_tracks(), "R8 pre-reset");
        do_reset("R8 mid-load reset");
        sweep(5, "R8 off after reset");

        finish_run();
    end

endmodule